// File: doc/BRIEF.md
# Aligned-Clock Synchronizing FIFO

This block is a first-in first-out buffer that moves data words from a source clock domain to a destination clock domain. One of the two clocks is an integer division of the other, and each slow rising edge lands exactly on a fast rising edge. Because the edges are aligned, each domain reads the other domain's pointer register directly, with no synchronizer flops and no pointer encoding. The write pointer belongs to the source domain and the read pointer belongs to the destination domain. Each pointer is one bit wider than the slot address.

Two qualifier inputs decide in which cycles each side may act. For a slow-to-fast crossing, the integrator ties `enq_allow` high and drives `deq_allow` with a pre-edge strobe. For a fast-to-slow crossing, the integrator drives `enq_allow` with that strobe and ties `deq_allow` high. The pre-edge strobe is high during the fast cycle that ends in a slow rising edge. With this pacing, the slow-side outputs hold steady for a whole slow cycle. Tying both qualifiers high lowers the minimum latency, but slow-side status can then change partway through a slow cycle.

Either side can clear the buffer. The two clears must not be raised in the same cycle.

Top module: `afa_aligned`

## Requirements
- R1: After a synchronous reset that spans at least one edge of each clock, `src_not_full` and `dst_not_full` read 1, and `src_not_empty` and `dst_not_empty` read 0.
- R2: A word on `enq_data` is stored only at a source edge where `enq_valid`, `enq_allow` and not-full are all 1. Words leave in the order they were stored.
- R3: An enqueue attempted while the FIFO holds 2^AW words is dropped. The stored contents and the word count stay unchanged.
- R4: The read pointer advances only at a destination edge where `deq_req`, `deq_allow` and `dst_not_empty` are all 1. A dequeue while empty, or while `deq_allow` is 0, has no effect.
- R5: Whenever `dst_not_empty` is 1, `deq_data` shows the oldest stored word.
- R6: Both not-full outputs read 0 exactly when 2^AW words are held. Both not-empty outputs read 1 exactly when at least one word is held. The word count never exceeds 2^AW.
- R7: `src_clear` empties the FIFO at the source edge that samples it. In that edge it overrides a simultaneous enqueue and blocks any dequeue.
- R8: `dst_clear` empties the FIFO at the destination edge that samples it. In that edge it overrides a simultaneous dequeue and blocks any enqueue.
- R9: The pointers wrap modulo 2^(AW+1), so data order and status stay correct over many more transfers than there are slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source domain clock |
| clk_dst | input | 1 | Destination domain clock, edge-aligned with clk_src |
| rst | input | 1 | Synchronous active-high reset, held across an edge of both clocks |
| enq_allow | input | 1 | Source-side qualifier: enqueue may act in this cycle |
| enq_valid | input | 1 | Enqueue request |
| enq_data | input | DW | Word to enqueue |
| src_clear | input | 1 | Empty the FIFO from the source side |
| src_not_full | output | 1 | Source view: room for one more word |
| src_not_empty | output | 1 | Source view: at least one word held |
| deq_allow | input | 1 | Destination-side qualifier: dequeue may act in this cycle |
| deq_req | input | 1 | Dequeue request |
| dst_clear | input | 1 | Empty the FIFO from the destination side |
| deq_data | output | DW | Oldest stored word |
| dst_not_full | output | 1 | Destination view: room for one more word |
| dst_not_empty | output | 1 | Destination view: at least one word held |

## Verification
The case of interest is an enqueue and a dequeue landing on the same aligned edge while the FIFO is full. Each side must decide from the other side's pointer as it stood before that edge. The bench fills all slots, waits for the fast cycle that precedes a slow edge, and then raises `enq_valid` and `deq_req` together. It expects the dequeue to take effect and the new word to be dropped: the FIFO afterwards holds one word fewer than full, and the remaining words come out in order. The same pre-edge method is used to pair each clear with an opposite-side request, to show that the clear wins.

// File: rtl/afa_pkg.sv
package afa_pkg;
  typedef struct packed {
    logic not_full;
    logic not_empty;
  } afa_view_t;

  function automatic afa_view_t make_view(input logic is_full, input logic is_empty);
    afa_view_t v;
    v.not_full  = ~is_full;
    v.not_empty = ~is_empty;
    return v;
  endfunction
endpackage

// File: rtl/afa_ptr.sv
module afa_ptr #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          clr,
  input  logic [PW-1:0] clr_to,
  output logic [PW-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (clr) ptr_q <= clr_to;
    else if (adv) ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/afa_store.sv
module afa_store #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int SLOTS = 1 << AW;

  logic [DW-1:0] mem [SLOTS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/afa_aligned.sv
module afa_aligned
  import afa_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk_src,
  input  logic          clk_dst,
  input  logic          rst,
  input  logic          enq_allow,
  input  logic          enq_valid,
  input  logic [DW-1:0] enq_data,
  input  logic          src_clear,
  output logic          src_not_full,
  output logic          src_not_empty,
  input  logic          deq_allow,
  input  logic          deq_req,
  input  logic          dst_clear,
  output logic [DW-1:0] deq_data,
  output logic          dst_not_full,
  output logic          dst_not_empty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] level;
  afa_view_t     src_view;
  afa_view_t     dst_view;
  logic          enq_fire;
  logic          deq_fire;

  // Aligned edges: each side reads the other's pointer register directly.
  assign level    = wr_ptr - rd_ptr;
  assign src_view = make_view(level[AW], level == '0);
  assign dst_view = make_view(level[AW], level == '0);

  // A clear on either side freezes both pointers' normal advance for that cycle.
  assign enq_fire = enq_valid & enq_allow & src_view.not_full & ~src_clear & ~dst_clear;
  assign deq_fire = deq_req & deq_allow & dst_view.not_empty & ~dst_clear & ~src_clear;

  afa_ptr #(.PW(PW)) u_wr (
    .clk(clk_src), .rst(rst), .adv(enq_fire),
    .clr(src_clear), .clr_to(rd_ptr), .ptr_q(wr_ptr)
  );

  afa_ptr #(.PW(PW)) u_rd (
    .clk(clk_dst), .rst(rst), .adv(deq_fire),
    .clr(dst_clear), .clr_to(wr_ptr), .ptr_q(rd_ptr)
  );

  afa_store #(.DW(DW), .AW(AW)) u_mem (
    .wclk(clk_src), .we(enq_fire), .waddr(wr_ptr[AW-1:0]), .wdata(enq_data),
    .raddr(rd_ptr[AW-1:0]), .rdata(deq_data)
  );

  assign src_not_full  = src_view.not_full;
  assign src_not_empty = src_view.not_empty;
  assign dst_not_full  = dst_view.not_full;
  assign dst_not_empty = dst_view.not_empty;
endmodule

// File: rtl/afa_chk.sv
module afa_chk #(
  parameter int AW = 2
) (
  input logic          clk_src,
  input logic          clk_dst,
  input logic          rst,
  input logic          enq_allow,
  input logic          src_clear,
  input logic          deq_allow,
  input logic          dst_clear,
  input logic          src_not_full,
  input logic          src_not_empty,
  input logic          dst_not_empty,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   rd_ptr
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = PW'(1 << AW);

  logic [PW-1:0] lvl;
  assign lvl = wr_ptr - rd_ptr;

  assert_enq_gate_R2: assert property (@(posedge clk_src) disable iff (rst)
    (!enq_allow && !src_clear) |=> $stable(wr_ptr));

  assert_full_drop_R3: assert property (@(posedge clk_src) disable iff (rst)
    (!src_not_full && !src_clear) |=> $stable(wr_ptr));

  assert_deq_gate_R4: assert property (@(posedge clk_dst) disable iff (rst)
    (!deq_allow && !dst_clear) |=> $stable(rd_ptr));

  assert_empty_deq_R4: assert property (@(posedge clk_dst) disable iff (rst)
    (!dst_not_empty && !dst_clear) |=> $stable(rd_ptr));

  assert_no_overflow_R6: assert property (@(posedge clk_src) disable iff (rst)
    lvl <= CAP);

  assert_src_clear_R7: assert property (@(posedge clk_src) disable iff (rst)
    src_clear |=> !src_not_empty);
endmodule

bind afa_aligned afa_chk #(.AW(AW)) u_chk (
  .clk_src(clk_src), .clk_dst(clk_dst), .rst(rst),
  .enq_allow(enq_allow), .src_clear(src_clear),
  .deq_allow(deq_allow), .dst_clear(dst_clear),
  .src_not_full(src_not_full), .src_not_empty(src_not_empty),
  .dst_not_empty(dst_not_empty), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/sim_afa_aligned.sv
`timescale 1ns/1ps
module sim_afa_aligned;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk_f, clk_s, rst;
  logic enq_allow, enq_valid, src_clear, deq_allow, deq_req, dst_clear;
  logic [DW-1:0] enq_data, deq_data;
  logic src_not_full, src_not_empty, dst_not_full, dst_not_empty;
  int n_chk = 0;
  int n_err = 0;

  // Fast source clock 250 MHz, destination clock divided by two, edges aligned.
  initial begin
    clk_f = 0; clk_s = 0;
    forever begin
      #2 clk_f = 1; clk_s = ~clk_s;
      #2 clk_f = 0;
    end
  end

  afa_aligned #(.DW(DW), .AW(AW)) u0 (
    .clk_src(clk_f), .clk_dst(clk_s), .rst(rst),
    .enq_allow(enq_allow), .enq_valid(enq_valid), .enq_data(enq_data),
    .src_clear(src_clear), .src_not_full(src_not_full), .src_not_empty(src_not_empty),
    .deq_allow(deq_allow), .deq_req(deq_req), .dst_clear(dst_clear),
    .deq_data(deq_data), .dst_not_full(dst_not_full), .dst_not_empty(dst_not_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic f_step;
    @(posedge clk_f); @(negedge clk_f);
  endtask

  // Park at the fast cycle whose closing edge is also a slow edge.
  task automatic to_pre;
    @(negedge clk_f);
    while (clk_s !== 1'b0) @(negedge clk_f);
  endtask

  task automatic push(input logic [DW-1:0] d);
    enq_valid = 1; enq_data = d; f_step; enq_valid = 0;
  endtask

  task automatic pop(input logic [DW-1:0] e, input string req);
    to_pre;
    chk({req, " not_empty"}, dst_not_empty, 1);
    chk({req, " data"}, deq_data, e);
    deq_req = 1; f_step; deq_req = 0;
  endtask

  task automatic t_reset;
    chk("R1 src_not_full", src_not_full, 1);
    chk("R1 src_not_empty", src_not_empty, 0);
    chk("R1 dst_not_full", dst_not_full, 1);
    chk("R1 dst_not_empty", dst_not_empty, 0);
  endtask

  task automatic t_order;
    push(8'h11); push(8'h22); push(8'h33);
    chk("R6 src_not_empty", src_not_empty, 1);
    chk("R6 dst_not_empty", dst_not_empty, 1);
    pop(8'h11, "R2 order"); pop(8'h22, "R5 head"); pop(8'h33, "R2 order");
    chk("R6 empty after drain", dst_not_empty, 0);
  endtask

  task automatic t_full;
    for (int k = 0; k < 5; k++) push(DW'(8'hA0 + k));
    chk("R6 src_not_full at cap", src_not_full, 0);
    chk("R6 dst_not_full at cap", dst_not_full, 0);
    for (int k = 0; k < 4; k++) pop(DW'(8'hA0 + k), "R3 full drop");
    chk("R3 fifth word dropped", dst_not_empty, 0);
  endtask

  task automatic t_deq_gate;
    push(8'h5C);
    deq_allow = 0; to_pre; deq_req = 1; f_step; f_step; f_step; deq_req = 0;
    chk("R4 gated not_empty", dst_not_empty, 1);
    chk("R4 gated data", deq_data, 8'h5C);
    deq_allow = 1;
    pop(8'h5C, "R4 pop");
    to_pre; deq_req = 1; f_step; f_step; f_step; deq_req = 0;
    chk("R4 empty deq not_empty", src_not_empty, 0);
    chk("R4 empty deq not_full", src_not_full, 1);
    push(8'h6D); pop(8'h6D, "R4 after empty deq");
  endtask

  task automatic t_enq_gate;
    logic [DW-1:0] exp_q [4];
    int n;
    enq_allow = 0; push(8'h77);
    chk("R2 disallowed enq", src_not_empty, 0);
    n = 0;
    for (int k = 0; k < 4; k++) begin
      enq_allow = (clk_s == 1'b0);
      enq_valid = 1; enq_data = DW'(8'h50 + k);
      if (enq_allow) begin exp_q[n] = enq_data; n++; end
      f_step;
    end
    enq_valid = 0; enq_allow = 1;
    for (int k = 0; k < n; k++) pop(exp_q[k], "R2 paced");
    chk("R2 paced count", dst_not_empty, 0);
  endtask

  task automatic t_src_clear;
    push(8'h81); push(8'h82);
    src_clear = 1; enq_valid = 1; enq_data = 8'h83; f_step;
    src_clear = 0; enq_valid = 0;
    chk("R7 src_not_empty", src_not_empty, 0);
    chk("R7 dst_not_empty", dst_not_empty, 0);
    chk("R7 src_not_full", src_not_full, 1);
    push(8'h84); pop(8'h84, "R7 reuse");
  endtask

  task automatic t_dst_clear;
    push(8'h91); push(8'h92); push(8'h93);
    to_pre; dst_clear = 1; deq_req = 1; f_step; dst_clear = 0; deq_req = 0;
    chk("R8 dst_not_empty", dst_not_empty, 0);
    chk("R8 src_not_empty", src_not_empty, 0);
    push(8'h94); pop(8'h94, "R8 reuse");
  endtask

  task automatic t_collide;
    for (int k = 0; k < 4; k++) push(DW'(8'h40 + k));
    to_pre; enq_valid = 1; enq_data = 8'h44; deq_req = 1; f_step;
    enq_valid = 0; deq_req = 0;
    chk("R3 collide not_full", src_not_full, 1);
    for (int k = 1; k < 4; k++) pop(DW'(8'h40 + k), "R3 collide");
    chk("R3 collide empty", dst_not_empty, 0);
  endtask

  task automatic t_wrap;
    push(8'h00);
    for (int k = 1; k < 12; k++) begin
      push(DW'(k * 7 + 3));
      pop(DW'(k == 1 ? 0 : (k - 1) * 7 + 3), "R9 wrap");
    end
    pop(DW'(11 * 7 + 3), "R9 wrap last");
    chk("R9 wrap empty", dst_not_empty, 0);
    chk("R9 wrap not_full", dst_not_full, 1);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    report;
  end

  initial begin
    rst = 1; enq_allow = 1; enq_valid = 0; enq_data = '0; src_clear = 0;
    deq_allow = 1; deq_req = 0; dst_clear = 0;
    repeat (4) f_step;
    rst = 0; f_step;
    t_reset;
    t_order;
    t_full;
    t_deq_gate;
    t_enq_gate;
    t_src_clear;
    t_dst_clear;
    t_collide;
    t_wrap;
    report;
  end
endmodule